// File: doc/BRIEF.md
# Divide-by-255 Normalizer

This unit turns an unsigned 16-bit intermediate value, usually a colour channel multiplied by an alpha, back into an 8-bit range by dividing it by 255. It has no divider. Dividing by 256 can be done with a shift, and 257/65536 is very close to 1/255. Three variants therefore use one adder with a different constant offset: x + (x >> 8) + c, then a shift right by 8. The fourth variant uses a single multiply by 257. A two-bit mode input picks the variant on each transfer.

The quotient is 9 bits wide because the largest inputs give results of 256 or 257. The result is registered. Each accepted input produces one output the following cycle, and its valid flag follows the input valid flag. While no input is offered, the last result stays on the output.

Top module: `div255_norm`

## Requirements
- R1: With mode = 0 (truncating), y equals (x + (x >> 8)) >> 8 for every x. For example x = 65535 gives 256 and x = 255 gives 0.
- R2: With mode = 1 (exact floor), y equals (x + 1 + (x >> 8)) >> 8. This equals floor(x/255) for every x from 0 to 65534. For x = 65535 the result is 256.
- R3: With mode = 1, an input of 255*k returns exactly k for every k from 0 to 255.
- R4: With mode = 2 (half-rounded), y equals (x + (x >> 8) + 128) >> 8 for every x. For example x = 127 gives 0, x = 128 gives 1, and x = 65535 gives 257.
- R5: With mode = 3 (round to nearest), y equals ((x + 128) * 257) >> 16. This equals x/255 rounded to the nearest integer for every x from 0 to 65535. For example x = 382 gives 1 and x = 383 gives 2.
- R6: out_valid in a cycle equals in_valid of the previous cycle. The y computed from the x and mode sampled with in_valid high appears in the next cycle.
- R7: While rst_n is low at a clock edge, out_valid and y are cleared to 0 after that edge.
- R8: A clock edge with in_valid low leaves y unchanged, whatever x and mode carry.
- R9: y never exceeds 257 in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | High when x and mode carry a value to normalize |
| x | input | 16 | Unsigned dividend |
| mode | input | 2 | Variant: 0 truncating, 1 exact floor, 2 half-rounded, 3 round to nearest |
| out_valid | output | 1 | in_valid delayed by one cycle |
| y | output | 9 | Registered quotient |

## Verification
The hardest cases to reach are the points where the shift-add approximation would be off by one. These are the exact multiples of 255 in floor mode, the half-way points in the rounding modes, and the top input 65535, where floor mode reaches its limit. The stimulus reaches all of them by sweeping every input value in the two exact modes. It also sweeps k*255 for every k and runs a table of hand-computed edge values. The hold behaviour is checked separately: x and mode change while in_valid is low, and the bench confirms that y does not follow them.

// File: rtl/div255_pkg.sv
// Package: shared mode encoding and constant helpers for the divide-by-255
// normalizer. Assumes the shift amount is at least 1.
package div255_pkg;

    typedef enum logic [1:0] {
        MODE_TRUNC   = 2'd0,
        MODE_FLOOR   = 2'd1,
        MODE_HALF    = 2'd2,
        MODE_NEAREST = 2'd3
    } norm_mode_e;

    localparam int NUM_MODES    = 4;
    localparam int NUM_SHIFTADD = 3;

    // Offset added by shift-add variant idx: 0, 1 or one half of 2**sh.
    function automatic int sa_offset(input int idx, input int sh);
        case (idx)
            0:       return 0;
            1:       return 1;
            default: return 1 << (sh - 1);
        endcase
    endfunction

endpackage

// File: rtl/div255_shift_add.sv
// Shift-add reciprocal stage: y = (x + (x >> SH) + OFFSET) >> SH.
// Assumes the sum width has one bit above IN_W, which is enough for
// OFFSET < 2**SH. Purely combinational.
module div255_shift_add #(
    parameter int IN_W   = 16,
    parameter int OUT_W  = 9,
    parameter int SH     = 8,
    parameter int OFFSET = 0
) (
    input  logic [IN_W-1:0]  x,
    output logic [OUT_W-1:0] y
);
    localparam int SUM_W = IN_W + 1;

    logic [SUM_W-1:0] sum;

    // Form the x*257/256 sum with the rounding offset, then scale by 1/256.
    always_comb begin
        sum = SUM_W'(x) + SUM_W'(x >> SH) + SUM_W'(OFFSET);
        y   = OUT_W'(sum >> SH);
    end
endmodule

// File: rtl/div255_mul_round.sv
// Constant-multiply stage with round to nearest:
// y = ((x + 2**(SH-1)) * (2**SH + 1)) >> (2*SH).
// The product width is sized so that no carry is lost. Combinational.
module div255_mul_round #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 9,
    parameter int SH    = 8
) (
    input  logic [IN_W-1:0]  x,
    output logic [OUT_W-1:0] y
);
    localparam int PROD_W = IN_W + SH + 2;
    localparam int MULT   = (1 << SH) + 1;
    localparam int HALF   = 1 << (SH - 1);

    logic [PROD_W-1:0] biased;
    logic [PROD_W-1:0] prod;

    // Bias the input by one half, multiply by 257 and keep the top bits.
    always_comb begin
        biased = PROD_W'(x) + PROD_W'(HALF);
        prod   = biased * PROD_W'(MULT);
        y      = OUT_W'(prod >> (2 * SH));
    end
endmodule

// File: rtl/div255_select.sv
// Variant selector: picks one of the four candidate quotients by mode.
// Assumes that candidate index i belongs to mode code i.
module div255_select
    import div255_pkg::*;
#(
    parameter int OUT_W = 9
) (
    input  logic [NUM_MODES-1:0][OUT_W-1:0] cand,
    input  logic [1:0]                      mode,
    output logic [OUT_W-1:0]                y
);
    // Route the candidate of the requested mode to the output.
    always_comb begin
        case (norm_mode_e'(mode))
            MODE_TRUNC:   y = cand[0];
            MODE_FLOOR:   y = cand[1];
            MODE_HALF:    y = cand[2];
            default:      y = cand[3];
        endcase
    end
endmodule

// File: rtl/div255_norm.sv
// Divide-by-255 normalizer, top level. All four variants are evaluated in
// parallel, one is selected by mode, and the result is registered. The
// result is loaded only when in_valid is high. out_valid follows in_valid
// one cycle later. Reset is synchronous and active low.
module div255_norm
    import div255_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int OUT_W = 9,
    parameter int SH    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  x,
    input  logic [1:0]       mode,
    output logic             out_valid,
    output logic [OUT_W-1:0] y
);
    logic [NUM_MODES-1:0][OUT_W-1:0] cand;
    logic [OUT_W-1:0]                y_next;

    // One shift-add stage per constant-offset variant.
    for (genvar g = 0; g < NUM_SHIFTADD; g++) begin : g_sa
        div255_shift_add #(
            .IN_W   (IN_W),
            .OUT_W  (OUT_W),
            .SH     (SH),
            .OFFSET (sa_offset(g, SH))
        ) i_sa (
            .x (x),
            .y (cand[g])
        );
    end

    div255_mul_round #(
        .IN_W  (IN_W),
        .OUT_W (OUT_W),
        .SH    (SH)
    ) i_mul (
        .x (x),
        .y (cand[NUM_MODES-1])
    );

    div255_select #(
        .OUT_W (OUT_W)
    ) i_sel (
        .cand (cand),
        .mode (mode),
        .y    (y_next)
    );

    // Output register: load on in_valid, delay the valid flag by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            y         <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                y <= y_next;
            end
        end
    end
endmodule

// File: rtl/div255_norm_chk.sv
// Checker for div255_norm: timing, hold, range and exactness properties,
// attached to every instance of the top module by bind.
module div255_norm_chk #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [IN_W-1:0]  x,
    input logic [1:0]       mode,
    input logic             out_valid,
    input logic [OUT_W-1:0] y
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R6

    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R6

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(y)); // R8

    AST_RANGE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> int'(y) <= 257); // R9

    AST_FLOOR_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd1 && x != '1) |=>
        (int'(y) * 255 <= int'($past(x)) && int'($past(x)) < (int'(y) + 1) * 255)); // R2

    AST_NEAREST_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd3) |=>
        (int'(y) * 255 <= int'($past(x)) + 127 && int'($past(x)) <= int'(y) * 255 + 127)); // R5
endmodule

bind div255_norm div255_norm_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) i_chk (.*);

// File: tb/test_div255_norm.sv
module test_div255_norm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] x = '0;
    logic [1:0]  mode = '0;
    logic        out_valid;
    logic [8:0]  y;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    div255_norm i_div255_norm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .x         (x),
        .mode      (mode),
        .out_valid (out_valid),
        .y         (y)
    );

    // Corner vectors: {mode, x, expected}
    localparam int NV = 18;
    localparam logic [26:0] VEC [NV] = '{
        {2'd0, 16'd0,     9'd0},
        {2'd0, 16'd255,   9'd0},
        {2'd0, 16'd510,   9'd1},
        {2'd0, 16'd65535, 9'd256},
        {2'd1, 16'd254,   9'd0},
        {2'd1, 16'd255,   9'd1},
        {2'd1, 16'd65280, 9'd256},
        {2'd1, 16'd65534, 9'd256},
        {2'd1, 16'd65535, 9'd256},
        {2'd2, 16'd127,   9'd0},
        {2'd2, 16'd128,   9'd1},
        {2'd2, 16'd383,   9'd2},
        {2'd2, 16'd65535, 9'd257},
        {2'd3, 16'd127,   9'd0},
        {2'd3, 16'd128,   9'd1},
        {2'd3, 16'd382,   9'd1},
        {2'd3, 16'd383,   9'd2},
        {2'd3, 16'd65535, 9'd257}
    };

    function automatic string tag_of(input logic [1:0] m);
        case (m)
            2'd0:    return "R1";
            2'd1:    return "R2";
            2'd2:    return "R4";
            default: return "R5";
        endcase
    endfunction

    function automatic int model(input int m, input int v);
        case (m)
            0:       return (v + (v >> 8)) >> 8;
            1:       return (v == 65535) ? 256 : v / 255;
            2:       return (v + (v >> 8) + 128) >> 8;
            default: return (v + 127) / 255;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive one transfer and check its result one cycle later.
    task automatic apply(input logic [1:0] m, input int v, input int exp, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        x        = 16'(v);
        mode     = m;
        @(posedge clk);
        #1;
        check(tag, int'(y), exp);
        if (out_valid !== 1'b1) check("R6", 0, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R7", int'(out_valid), 0);
        check("R7", int'(y), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][26:25], int'(VEC[i][24:9]), int'(VEC[i][8:0]), tag_of(VEC[i][26:25]));
        end

        // R3: every multiple 255*k in floor mode
        for (int k = 0; k < 256; k++) apply(2'd1, 255 * k, k, "R3");

        // Full sweeps of the exact modes (R2, R5)
        for (int v = 0; v < 65536; v++) apply(2'd1, v, model(1, v), "R2");
        for (int v = 0; v < 65536; v++) apply(2'd3, v, model(3, v), "R5");

        // Strided sweeps of the approximate modes (R1, R4), end point included
        for (int v = 0; v < 65536; v += 13) apply(2'd0, v, model(0, v), "R1");
        apply(2'd0, 65535, model(0, 65535), "R1");
        for (int v = 0; v < 65536; v += 13) apply(2'd2, v, model(2, v), "R4");
        apply(2'd2, 65535, model(2, 65535), "R4");

        // R9: the top input in every mode stays within 257
        for (int m = 0; m < 4; m++) begin
            apply(2'(m), 65535, model(m, 65535), "R9");
            check("R9", int'(y <= 9'd257), 1);
        end

        // R8 / R6: idle cycle with changing inputs holds y and drops out_valid
        apply(2'd3, 1000, 4, "R5");
        @(negedge clk);
        in_valid = 1'b0;
        x        = 16'd65535;
        mode     = 2'd2;
        @(posedge clk);
        #1;
        check("R8", int'(y), 4);
        check("R6", int'(out_valid), 0);
        @(negedge clk);
        x = 16'd300;
        @(posedge clk);
        #1;
        check("R8", int'(y), 4);

        // R6: result appears after exactly one cycle
        apply(2'd1, 510, 2, "R6");

        // R7: mid-run reset clears state
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        check("R7", int'(out_valid), 0);
        check("R7", int'(y), 0);
        @(negedge clk);
        rst_n    = 1'b1;
        in_valid = 1'b0;

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (195000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule